// File: doc/BRIEF.md
# Display Controller Interrupt Status Unit

This block collects the interrupt sources of a seven-channel display controller into two status registers and a single interrupt line. Each channel reports start-of-frame, end-of-frame, branch and bus-error events as one-cycle pulses. The controller itself reports disable-done, output-underrun, read-status and command-complete events, and the first two channels also report input underrun. Channel 0 and the controller events land in a primary status word. Channels 1 to 6 land in a secondary status word. Software clears bits by writing ones to them.

Each source has a mask bit. The primary masks live in the controller's main control word, which this block stores together with its enable and internal-buffer bits. The secondary masks live in a mask word that uses the secondary status layout. An unmasked frame event, or any bus error, sets a summary bit and loads that channel's frame ID into an interrupt-ID register, so the handler knows which descriptor raised it. A bus error also records the channel number.

Top module: `disp_irq_status`

## Requirements
- R1: Primary status bit positions: 0 disable done, 1 SOF channel 0, 2 bus error, 3 AC-bias count, 4 underrun channel 0, 5 underrun channel 1, 6 output underrun, 7 quick disable, 8 EOF channel 0, 9 branch channel 0, 10 summary, 11 read status, 12 command. Bits 30:28 hold the bus-error channel. All other bits read zero. Each event pulse sets its bit at the next clock edge.
- R2: For a channel n from 1 to 6, the secondary status word places SOF at bit n-1, EOF at bit n+7 and branch at bit n+15. Bits 29:24 are reserved for underrun of channel n at bit n+23, and no input sets them.
- R3: `irq` is a register. After each edge it equals the OR of every masked-off-able primary source ANDed with the inverse of its mask bit. The control-word mask positions are: 3 disable done, 4 SOF, 5 underrun ch0, 6 EOF, 11 quick disable, 20 branch, 21 output underrun, 23 read status, 24 command. Primary bits 2, 3 and 10 never drive `irq`.
- R4: Any secondary status bit whose secondary mask bit is clear drives `irq`. Primary bit 5 (underrun of channel 1) is masked by secondary mask bit 24.
- R5: An unmasked SOF, EOF or branch event, or any bus error, sets primary bit 10 and loads `int_id` with that channel's frame ID. When several channels hit in one cycle, the highest channel wins. A masked frame event changes neither `int_id` nor bit 10.
- R6: A bus error sets primary bit 2 and writes its channel number to bits 30:28. The highest channel wins.
- R7: A write to address 2 clears the primary bits written as one, within bits 11:0. Bit 12 is not affected. Writing one to bit 2 also zeroes bits 30:28.
- R8: A write to address 3 clears the secondary bits written as one, within the mask 0x003E3F3F. Branch of channel 1 (bit 16) is not cleared by it.
- R9: A control write that clears bit 0 (enable) while it was set raises primary bit 7.
- R10: A control write that sets bit 0 with bit 22 (internal buffer) clear, while `acb_nonzero` is high, raises primary bit 3.
- R11: When an event and a clear write hit the same bit in one cycle, the bit ends up set. For the bus-error bit, the channel field takes the new channel.
- R12: After reset, both status words, `int_id` and `irq` are zero, and all masks and the enable bit are clear.
- R13: Address 0 writes the control word, which keeps bits 26:0. Address 1 writes the secondary mask, which keeps 0x3F3F3F3F. A mask change affects `irq` from the edge of the write onward. It affects summary and ID capture only for events in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_sof | input | NCH | Start-of-frame pulse per channel |
| ev_eof | input | NCH | End-of-frame pulse per channel |
| ev_branch | input | NCH | Branch-taken pulse per channel |
| ev_buserr | input | NCH | Bus-error pulse per channel |
| ev_underrun | input | 2 | Input underrun pulse, channels 0 and 1 |
| ev_dis_done | input | 1 | Disable-done pulse |
| ev_out_underrun | input | 1 | Output underrun pulse |
| ev_rd_status | input | 1 | Panel read-status pulse |
| ev_cmd | input | 1 | Command-complete pulse |
| acb_nonzero | input | 1 | AC-bias count field is nonzero |
| frame_ids | input | NCH*IDW | Frame ID of each channel, channel c at bits c*IDW upward |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 secondary mask, 2 primary status, 3 secondary status |
| wr_data | input | 32 | Write data |
| prim_status | output | 32 | Primary status word |
| sec_status | output | 32 | Secondary status word |
| int_id | output | IDW | Frame ID of the last recorded source |
| irq | output | 1 | Interrupt request |

## Verification
Directed cases cover the following:
- a masked and an unmasked SOF on channel 0, which tell the mask check for ID capture apart from status setting;
- an EOF on channel 3 followed by masking its secondary bit, which separates the secondary path from the primary one;
- bus errors on two channels at once, which expose the priority used for the channel field and the ID;
- a clear that lands together with a new bus error, which shows whether the event wins;
- clear writes aimed at the command bit and at the channel-1 branch bit, which confirm that those bits are outside the clearable range.

A long random phase then mixes sparse pulses on all sources with random writes to all four addresses. Every output is compared each cycle against a model built from the requirements. This catches wrong bit positions, wrong mask pairings and wrong write masks.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;
  // primary status positions
  localparam int PS_DIS_DONE = 0;
  localparam int PS_SOF0     = 1;
  localparam int PS_BUSERR   = 2;
  localparam int PS_ACB      = 3;
  localparam int PS_UR0      = 4;
  localparam int PS_UR1      = 5;
  localparam int PS_OUT_UR   = 6;
  localparam int PS_QDIS     = 7;
  localparam int PS_EOF0     = 8;
  localparam int PS_BR0      = 9;
  localparam int PS_SUM      = 10;
  localparam int PS_RDST     = 11;
  localparam int PS_CMD      = 12;
  localparam int PS_BCH_LO   = 28;
  localparam int PS_CLR_W    = 12;
  // control word fields
  localparam int CM_EN       = 0;
  localparam int CM_DIS_DONE = 3;
  localparam int CM_SOF      = 4;
  localparam int CM_UR0      = 5;
  localparam int CM_EOF      = 6;
  localparam int CM_QDIS     = 11;
  localparam int CM_BR       = 20;
  localparam int CM_OUT_UR   = 21;
  localparam int CM_INTBUF   = 22;
  localparam int CM_RDST     = 23;
  localparam int CM_CMD      = 24;
  // secondary layout bases (channel n uses base + n - 1)
  localparam int SEC_SOF = 0;
  localparam int SEC_EOF = 8;
  localparam int SEC_BR  = 16;
  localparam int SEC_UR  = 24;
  localparam logic [31:0] CTL_KEEP   = 32'h07FF_FFFF;
  localparam logic [31:0] SMASK_KEEP = 32'h3F3F_3F3F;
  localparam logic [31:0] SCLR_KEEP  = 32'h003E_3F3F;
  typedef enum logic [1:0] {
    RA_CTL   = 2'd0,
    RA_SMASK = 2'd1,
    RA_PSTAT = 2'd2,
    RA_SSTAT = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/disp_irq_collect.sv
module disp_irq_collect
  import disp_irq_pkg::*;
#(
  parameter int NCH = 7,
  parameter int IDW = 32,
  parameter int CHW = 3
) (
  input  logic [NCH-1:0]     ev_sof,
  input  logic [NCH-1:0]     ev_eof,
  input  logic [NCH-1:0]     ev_branch,
  input  logic [NCH-1:0]     ev_buserr,
  input  logic [1:0]         ev_underrun,
  input  logic               ev_dis_done,
  input  logic               ev_out_underrun,
  input  logic               ev_rd_status,
  input  logic               ev_cmd,
  input  logic [NCH*IDW-1:0] frame_ids,
  input  logic [31:0]        ctl_q,
  input  logic [31:0]        smask_q,
  output logic [31:0]        pset,
  output logic [31:0]        sset,
  output logic               hit,
  output logic [IDW-1:0]     id_sel,
  output logic               ber_hit,
  output logic [CHW-1:0]     ber_ch
);
  logic [NCH-1:0] uhit;
  logic           unused_sink;
  assign unused_sink = ^{ctl_q, smask_q};

  // per-channel "records its ID" flag, mask source picked by channel
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    if (g == 0) begin : g_prim
      assign uhit[g] = (ev_branch[g] & ~ctl_q[CM_BR])
                     | (ev_sof[g]    & ~ctl_q[CM_SOF])
                     | (ev_eof[g]    & ~ctl_q[CM_EOF])
                     | ev_buserr[g];
    end else begin : g_sec
      assign uhit[g] = (ev_branch[g] & ~smask_q[SEC_BR  + g - 1])
                     | (ev_sof[g]    & ~smask_q[SEC_SOF + g - 1])
                     | (ev_eof[g]    & ~smask_q[SEC_EOF + g - 1])
                     | ev_buserr[g];
    end
  end

  always_comb begin
    pset              = '0;
    pset[PS_SOF0]     = ev_sof[0];
    pset[PS_EOF0]     = ev_eof[0];
    pset[PS_BR0]      = ev_branch[0];
    pset[PS_BUSERR]   = |ev_buserr;
    pset[PS_UR0]      = ev_underrun[0];
    pset[PS_UR1]      = ev_underrun[1];
    pset[PS_DIS_DONE] = ev_dis_done;
    pset[PS_OUT_UR]   = ev_out_underrun;
    pset[PS_RDST]     = ev_rd_status;
    pset[PS_CMD]      = ev_cmd;
    sset = '0;
    for (int c = 1; c < NCH; c++) begin
      sset[SEC_SOF + c - 1] = ev_sof[c];
      sset[SEC_EOF + c - 1] = ev_eof[c];
      sset[SEC_BR  + c - 1] = ev_branch[c];
    end
  end

  // ascending scan: the highest hitting channel is the one kept
  always_comb begin
    hit     = 1'b0;
    id_sel  = '0;
    ber_hit = 1'b0;
    ber_ch  = '0;
    for (int c = 0; c < NCH; c++) begin
      if (uhit[c]) begin
        hit    = 1'b1;
        id_sel = frame_ids[c*IDW +: IDW];
      end
      if (ev_buserr[c]) begin
        ber_hit = 1'b1;
        ber_ch  = CHW'(c);
      end
    end
  end
endmodule

// File: rtl/disp_irq_regs.sv
module disp_irq_regs
  import disp_irq_pkg::*;
#(
  parameter int IDW = 32,
  parameter int CHW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [1:0]     wr_addr,
  input  logic [31:0]    wr_data,
  input  logic           acb_nonzero,
  input  logic [31:0]    pset,
  input  logic [31:0]    sset,
  input  logic           hit,
  input  logic [IDW-1:0] id_sel,
  input  logic           ber_hit,
  input  logic [CHW-1:0] ber_ch,
  output logic [31:0]    ctl_q,
  output logic [31:0]    smask_q,
  output logic [31:0]    pst_q,
  output logic [31:0]    sst_q,
  output logic [IDW-1:0] id_q,
  output logic [31:0]    ctl_d,
  output logic [31:0]    smask_d,
  output logic [31:0]    pst_d,
  output logic [31:0]    sst_d
);
  logic        wr_ctl, wr_smask, wr_pst, wr_sst;
  logic        qdis, acb, id_en;
  logic [31:0] pclr, sclr;

  always_comb begin
    wr_ctl   = wr_en && (wr_addr == RA_CTL);
    wr_smask = wr_en && (wr_addr == RA_SMASK);
    wr_pst   = wr_en && (wr_addr == RA_PSTAT);
    wr_sst   = wr_en && (wr_addr == RA_SSTAT);
    qdis     = wr_ctl && ctl_q[CM_EN] && !wr_data[CM_EN];
    acb      = wr_ctl && wr_data[CM_EN] && !wr_data[CM_INTBUF] && acb_nonzero;
    pclr     = wr_pst ? {{(32-PS_CLR_W){1'b0}}, wr_data[PS_CLR_W-1:0]} : '0;
    sclr     = wr_sst ? (wr_data & SCLR_KEEP) : '0;
    id_en    = hit;

    ctl_d   = wr_ctl   ? (wr_data & CTL_KEEP)   : ctl_q;
    smask_d = wr_smask ? (wr_data & SMASK_KEEP) : smask_q;

    pst_d = '0;
    pst_d[PS_CMD:0] = (pst_q[PS_CMD:0] & ~pclr[PS_CMD:0]) | pset[PS_CMD:0];
    pst_d[PS_QDIS]  = pst_d[PS_QDIS] | qdis;
    pst_d[PS_ACB]   = pst_d[PS_ACB]  | acb;
    pst_d[PS_SUM]   = pst_d[PS_SUM]  | hit;
    if (ber_hit)
      pst_d[PS_BCH_LO +: CHW] = ber_ch;
    else if (pclr[PS_BUSERR])
      pst_d[PS_BCH_LO +: CHW] = '0;
    else
      pst_d[PS_BCH_LO +: CHW] = pst_q[PS_BCH_LO +: CHW];

    sst_d = (sst_q & ~sclr) | sset;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      smask_q <= '0;
      pst_q   <= '0;
      sst_q   <= '0;
      id_q    <= '0;
    end else begin
      ctl_q   <= ctl_d;
      smask_q <= smask_d;
      pst_q   <= pst_d;
      sst_q   <= sst_d;
      if (id_en) id_q <= id_sel;
    end
  end
endmodule

// File: rtl/disp_irq_combine.sv
module disp_irq_combine
  import disp_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] pst_d,
  input  logic [31:0] sst_d,
  input  logic [31:0] ctl_d,
  input  logic [31:0] smask_d,
  output logic        irq
);
  logic irq_d;
  logic unused_sink;
  assign unused_sink = ^{pst_d, ctl_d};

  always_comb begin
    irq_d = (pst_d[PS_DIS_DONE] & ~ctl_d[CM_DIS_DONE])
          | (pst_d[PS_SOF0]     & ~ctl_d[CM_SOF])
          | (pst_d[PS_UR0]      & ~ctl_d[CM_UR0])
          | (pst_d[PS_UR1]      & ~smask_d[SEC_UR])
          | (pst_d[PS_OUT_UR]   & ~ctl_d[CM_OUT_UR])
          | (pst_d[PS_QDIS]     & ~ctl_d[CM_QDIS])
          | (pst_d[PS_EOF0]     & ~ctl_d[CM_EOF])
          | (pst_d[PS_BR0]      & ~ctl_d[CM_BR])
          | (pst_d[PS_RDST]     & ~ctl_d[CM_RDST])
          | (pst_d[PS_CMD]      & ~ctl_d[CM_CMD])
          | (|(sst_d & ~smask_d));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end
endmodule

// File: rtl/disp_irq_status.sv
module disp_irq_status
  import disp_irq_pkg::*;
#(
  parameter int NCH = 7,
  parameter int IDW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCH-1:0]     ev_sof,
  input  logic [NCH-1:0]     ev_eof,
  input  logic [NCH-1:0]     ev_branch,
  input  logic [NCH-1:0]     ev_buserr,
  input  logic [1:0]         ev_underrun,
  input  logic               ev_dis_done,
  input  logic               ev_out_underrun,
  input  logic               ev_rd_status,
  input  logic               ev_cmd,
  input  logic               acb_nonzero,
  input  logic [NCH*IDW-1:0] frame_ids,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [31:0]        wr_data,
  output logic [31:0]        prim_status,
  output logic [31:0]        sec_status,
  output logic [IDW-1:0]     int_id,
  output logic               irq
);
  localparam int CHW = $clog2(NCH);

  logic [31:0]    pset, sset;
  logic           hit, ber_hit;
  logic [IDW-1:0] id_sel;
  logic [CHW-1:0] ber_ch;
  logic [31:0]    ctl_q, smask_q, pst_q, sst_q;
  logic [31:0]    ctl_d, smask_d, pst_d, sst_d;
  logic [IDW-1:0] id_q;

  disp_irq_collect #(.NCH(NCH), .IDW(IDW), .CHW(CHW)) u_collect (
    .ev_sof(ev_sof), .ev_eof(ev_eof), .ev_branch(ev_branch),
    .ev_buserr(ev_buserr), .ev_underrun(ev_underrun),
    .ev_dis_done(ev_dis_done), .ev_out_underrun(ev_out_underrun),
    .ev_rd_status(ev_rd_status), .ev_cmd(ev_cmd),
    .frame_ids(frame_ids), .ctl_q(ctl_q), .smask_q(smask_q),
    .pset(pset), .sset(sset), .hit(hit), .id_sel(id_sel),
    .ber_hit(ber_hit), .ber_ch(ber_ch)
  );

  disp_irq_regs #(.IDW(IDW), .CHW(CHW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .acb_nonzero(acb_nonzero),
    .pset(pset), .sset(sset), .hit(hit), .id_sel(id_sel),
    .ber_hit(ber_hit), .ber_ch(ber_ch),
    .ctl_q(ctl_q), .smask_q(smask_q), .pst_q(pst_q), .sst_q(sst_q),
    .id_q(id_q), .ctl_d(ctl_d), .smask_d(smask_d), .pst_d(pst_d),
    .sst_d(sst_d)
  );

  disp_irq_combine u_combine (
    .clk(clk), .rst_n(rst_n), .pst_d(pst_d), .sst_d(sst_d),
    .ctl_d(ctl_d), .smask_d(smask_d), .irq(irq)
  );

  assign prim_status = pst_q;
  assign sec_status  = sst_q;
  assign int_id      = id_q;
endmodule

// File: rtl/disp_irq_status_chk.sv
module disp_irq_status_chk #(
  parameter int NCH = 7,
  parameter int IDW = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] ev_sof,
  input logic [NCH-1:0] ev_eof,
  input logic [NCH-1:0] ev_branch,
  input logic [NCH-1:0] ev_buserr,
  input logic           wr_en,
  input logic [1:0]     wr_addr,
  input logic [31:0]    wr_data,
  input logic [31:0]    ctl_q,
  input logic [31:0]    smask_q,
  input logic [31:0]    prim_status,
  input logic [31:0]    sec_status,
  input logic [IDW-1:0] int_id,
  input logic           irq
);
  logic exp_irq;
  logic unused_sink;
  assign unused_sink = ^{wr_data, ctl_q};
  assign exp_irq = (prim_status[0] & ~ctl_q[3]) | (prim_status[1] & ~ctl_q[4])
                 | (prim_status[4] & ~ctl_q[5]) | (prim_status[5] & ~smask_q[24])
                 | (prim_status[6] & ~ctl_q[21]) | (prim_status[7] & ~ctl_q[11])
                 | (prim_status[8] & ~ctl_q[6]) | (prim_status[9] & ~ctl_q[20])
                 | (prim_status[11] & ~ctl_q[23]) | (prim_status[12] & ~ctl_q[24])
                 | (|(sec_status & ~smask_q));

  assert_irq_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq == exp_irq);
  assert_sof0_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sof[0] |=> prim_status[1]);
  assert_layout_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    prim_status[27:13] == '0 && !prim_status[31]);
  assert_sec_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_status & ~32'h003F_3F3F) == '0);
  assert_id_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(|{ev_sof, ev_eof, ev_branch, ev_buserr}) |=> $stable(int_id));
  assert_buserr_sum_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_buserr) |=> prim_status[2] && prim_status[10]);
  assert_ber_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == 2'd2 && wr_data[2] && !(|ev_buserr)
    |=> !prim_status[2] && prim_status[30:28] == 3'd0);
  assert_cmd_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prim_status[12] |=> prim_status[12]);
  assert_qdis_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == 2'd0 && ctl_q[0] && !wr_data[0] |=> prim_status[7]);
endmodule

bind disp_irq_status disp_irq_status_chk #(.NCH(NCH), .IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_sof(ev_sof), .ev_eof(ev_eof),
  .ev_branch(ev_branch), .ev_buserr(ev_buserr), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .ctl_q(ctl_q), .smask_q(smask_q),
  .prim_status(prim_status), .sec_status(sec_status), .int_id(int_id),
  .irq(irq)
);

// File: tb/tb_disp_irq_status.sv
`timescale 1ns/1ps
module tb_disp_irq_status;
  localparam int NCH = 7;
  localparam int IDW = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCH-1:0] ev_sof, ev_eof, ev_branch, ev_buserr;
  logic [1:0] ev_underrun;
  logic ev_dis_done, ev_out_underrun, ev_rd_status, ev_cmd, acb_nonzero;
  logic [NCH*IDW-1:0] frame_ids;
  logic wr_en;
  logic [1:0] wr_addr;
  logic [31:0] wr_data;
  logic [31:0] prim_status, sec_status;
  logic [IDW-1:0] int_id;
  logic irq;

  always #2 clk = ~clk;

  disp_irq_status #(.NCH(NCH), .IDW(IDW)) dut (
    .clk(clk), .rst_n(rst_n), .ev_sof(ev_sof), .ev_eof(ev_eof),
    .ev_branch(ev_branch), .ev_buserr(ev_buserr), .ev_underrun(ev_underrun),
    .ev_dis_done(ev_dis_done), .ev_out_underrun(ev_out_underrun),
    .ev_rd_status(ev_rd_status), .ev_cmd(ev_cmd), .acb_nonzero(acb_nonzero),
    .frame_ids(frame_ids), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .prim_status(prim_status), .sec_status(sec_status),
    .int_id(int_id), .irq(irq)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] m_ctl, m_smask, m_pst, m_sst;
  logic [IDW-1:0] m_id;
  logic m_irq;

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic calc_irq(logic [31:0] p, logic [31:0] s,
                                    logic [31:0] c, logic [31:0] sm);
    return (p[0] & ~c[3]) | (p[1] & ~c[4]) | (p[4] & ~c[5]) | (p[5] & ~sm[24])
         | (p[6] & ~c[21]) | (p[7] & ~c[11]) | (p[8] & ~c[6]) | (p[9] & ~c[20])
         | (p[11] & ~c[23]) | (p[12] & ~c[24]) | (|(s & ~sm));
  endfunction

  // reference model of one clock edge, from the requirements
  task automatic model_step();
    logic [31:0] ps = '0, ss = '0, clr = '0;
    logic hit = 0, bh = 0;
    logic [2:0] bch = '0;
    for (int c = 0; c < NCH; c++) begin
      logic u;
      if (c == 0) begin
        ps[1] = ev_sof[0]; ps[8] = ev_eof[0]; ps[9] = ev_branch[0];
        u = (ev_sof[0] & ~m_ctl[4]) | (ev_eof[0] & ~m_ctl[6]) | (ev_branch[0] & ~m_ctl[20]);
      end else begin
        ss[c-1] = ev_sof[c]; ss[c+7] = ev_eof[c]; ss[c+15] = ev_branch[c];
        u = (ev_sof[c] & ~m_smask[c-1]) | (ev_eof[c] & ~m_smask[c+7])
          | (ev_branch[c] & ~m_smask[c+15]);
      end
      if (ev_buserr[c]) begin u = 1; bh = 1; bch = 3'(c); end
      if (u) begin hit = 1; m_id = frame_ids[c*IDW +: IDW]; end
    end
    ps[2] = bh; ps[4] = ev_underrun[0]; ps[5] = ev_underrun[1];
    ps[0] = ev_dis_done; ps[6] = ev_out_underrun; ps[11] = ev_rd_status; ps[12] = ev_cmd;
    ps[10] = hit;
    if (wr_en && wr_addr == 2'd0) begin
      if (m_ctl[0] && !wr_data[0]) ps[7] = 1;
      if (wr_data[0] && !wr_data[22] && acb_nonzero) ps[3] = 1;
      m_ctl = wr_data & 32'h07FF_FFFF;
    end
    if (wr_en && wr_addr == 2'd1) m_smask = wr_data & 32'h3F3F_3F3F;
    if (wr_en && wr_addr == 2'd2) clr = {20'd0, wr_data[11:0]};
    if (wr_en && wr_addr == 2'd3) m_sst = m_sst & ~(wr_data & 32'h003E_3F3F);
    m_sst = m_sst | ss;
    m_pst[12:0] = (m_pst[12:0] & ~clr[12:0]) | ps[12:0];
    if (bh) m_pst[30:28] = bch;
    else if (clr[2]) m_pst[30:28] = 3'd0;
    m_irq = calc_irq(m_pst, m_sst, m_ctl, m_smask);
  endtask

  task automatic idle();
    ev_sof = '0; ev_eof = '0; ev_branch = '0; ev_buserr = '0;
    ev_underrun = '0; ev_dis_done = 0; ev_out_underrun = 0;
    ev_rd_status = 0; ev_cmd = 0; wr_en = 0; wr_addr = '0; wr_data = '0;
  endtask

  // inputs are set at the falling edge before this call
  task automatic run_cycle(string tag);
    model_step();
    @(posedge clk); #1;
    check({tag, " prim_status"}, prim_status, m_pst);
    check({tag, " sec_status"}, sec_status, m_sst);
    check({tag, " int_id"}, int_id, m_id);
    check({tag, " irq"}, {31'd0, irq}, {31'd0, m_irq});
    @(negedge clk);
    idle();
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    idle();
    acb_nonzero = 0;
    rst_n = 0;
    for (int c = 0; c < NCH; c++) frame_ids[c*IDW +: IDW] = 32'hA000_0000 + 32'(c * 17);
    m_ctl = '0; m_smask = '0; m_pst = '0; m_sst = '0; m_id = '0; m_irq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R12: reset state
    check("R12 prim_status", prim_status, 0);
    check("R12 sec_status", sec_status, 0);
    check("R12 int_id", int_id, 0);
    check("R12 irq", {31'd0, irq}, 0);

    // R1 R5: unmasked SOF on channel 0
    ev_sof[0] = 1; run_cycle("R1 R5 sof0");
    check("R5 id loaded", int_id, 32'hA000_0000);
    check("R1 sof bit", {31'd0, prim_status[1]}, 1);
    // R13 R3: enable plus SOF mask, then clear and retry masked
    wr(2'd0, 32'h0000_0011); run_cycle("R13 ctl write");
    wr(2'd2, 32'h0000_0FFF); run_cycle("R7 clear all");
    frame_ids[0 +: IDW] = 32'h0000_0022;
    ev_sof[0] = 1; run_cycle("R5 masked sof0");
    check("R5 masked id kept", int_id, 32'hA000_0000);
    check("R5 masked no summary", {31'd0, prim_status[10]}, 0);
    check("R3 masked sof no irq", {31'd0, irq}, 0);
    // R2: EOF on channel 3 lands at bit 10
    ev_eof[3] = 1; run_cycle("R2 eof3");
    check("R2 eof3 bit", {31'd0, sec_status[10]}, 1);
    check("R4 sec irq", {31'd0, irq}, 1);
    wr(2'd1, 32'h0000_0400); run_cycle("R4 R13 mask eof3");
    check("R4 masked sec irq", {31'd0, irq}, 0);
    // R8: branch ch1 at bit 16 survives a full clear
    ev_branch[1] = 1; run_cycle("R2 branch1");
    wr(2'd3, 32'hFFFF_FFFF); run_cycle("R8 clear sec");
    check("R8 bit16 kept", {31'd0, sec_status[16]}, 1);
    check("R8 bit10 cleared", {31'd0, sec_status[10]}, 0);
    // R7: command bit outside clear range
    ev_cmd = 1; run_cycle("R1 cmd");
    wr(2'd2, 32'hFFFF_FFFF); run_cycle("R7 clear cmd attempt");
    check("R7 cmd kept", {31'd0, prim_status[12]}, 1);
    // R6: two bus errors at once, highest channel wins
    ev_buserr = 7'b010_0100; run_cycle("R6 two buserr");
    check("R6 channel field", {29'd0, prim_status[30:28]}, 5);
    check("R5 id highest", int_id, 32'hA000_0000 + 32'(5 * 17));
    // R11: clear and new bus error in one cycle
    wr(2'd2, 32'h0000_0004); ev_buserr[1] = 1; run_cycle("R11 event wins");
    check("R11 bit2", {31'd0, prim_status[2]}, 1);
    check("R11 field", {29'd0, prim_status[30:28]}, 1);
    wr(2'd2, 32'h0000_0004); run_cycle("R7 ber clear");
    check("R7 field zero", {29'd0, prim_status[30:28]}, 0);
    // R9: quick disable
    wr(2'd0, 32'h0000_0000); run_cycle("R9 disable");
    check("R9 qdis bit", {31'd0, prim_status[7]}, 1);
    // R10: AC-bias count status
    acb_nonzero = 1;
    wr(2'd0, 32'h0040_0001); run_cycle("R10 intbuf set no acb");
    check("R10 no acb", {31'd0, prim_status[3]}, 0);
    wr(2'd0, 32'h0000_0001); run_cycle("R10 acb raised");
    check("R10 acb bit", {31'd0, prim_status[3]}, 1);
    acb_nonzero = 0;
    // R4: underrun ch1 masked by secondary bit 24
    wr(2'd2, 32'h0000_0FFF); run_cycle("R7 clear");
    wr(2'd1, 32'h3F3F_3F3F); run_cycle("R13 mask all sec");
    wr(2'd0, 32'h01FF_FFF9); run_cycle("R13 mask all prim");
    ev_underrun[1] = 1; run_cycle("R4 ur1 masked");
    check("R4 ur1 masked irq", {31'd0, irq}, 0);
    wr(2'd1, 32'h0000_0000); run_cycle("R4 ur1 unmasked");
    check("R4 ur1 unmasked irq", {31'd0, irq}, 1);

    // random phase: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R13
    for (int i = 0; i < 4000; i++) begin
      for (int c = 0; c < NCH; c++) begin
        ev_sof[c] = ($urandom % 8) == 0;
        ev_eof[c] = ($urandom % 8) == 0;
        ev_branch[c] = ($urandom % 10) == 0;
        ev_buserr[c] = ($urandom % 25) == 0;
        frame_ids[c*IDW +: IDW] = $urandom;
      end
      ev_underrun = 2'($urandom % 4 == 0 ? $urandom : 0);
      ev_dis_done = ($urandom % 12) == 0;
      ev_out_underrun = ($urandom % 12) == 0;
      ev_rd_status = ($urandom % 12) == 0;
      ev_cmd = ($urandom % 30) == 0;
      acb_nonzero = $urandom;
      if (($urandom % 3) == 0) wr(2'($urandom), $urandom);
      run_cycle("R1 R3 R5 random");
    end
    done = 1;
    summary();
  end
endmodule